// File: doc/BRIEF.md
# Damping Gain Auto-Tuning Controller

This block is a small digital sequencer that picks the feedback gain code for a ripple-regulated buck converter's capacitor-current loop. The code drives an external switched-resistor bank. The block starts from a large code, which leaves the loop heavily damped. It then repeatedly pulses a step request into the control reference and lowers the code until the output first rings past a threshold.

Each search iteration raises a perturbation request. In the same cycle it opens an enable window for an external overshoot comparator. The window closes after a fixed number of switching-cycle ticks, and the pulse ends after a longer count.

One cycle after the pulse falls, the block makes its decision:
- If the comparator stayed quiet during the window, the code shrinks by roughly a fifth.
- If the comparator fired, the code goes back to the previous iteration's value and the block reports completion.
- If the code reaches its floor with no overshoot seen, the block stops there and raises a separate flag.

The search runs only while the start input is held high. That input is driven by the upstream time-constant calibration once the output voltage has settled. Releasing start aborts the search at once and reloads the initial code.

Top module: `damp_gain_tuner`

## Requirements
- R1: After reset, `gain_code` equals GAIN_START and `perturb_req`, `cmp_en`, `done` and `floor_hit` are all 0.
- R2: While `start` is low nothing is issued. The first `perturb_req` rise occurs on the first clock edge at which `start` is sampled high in the idle state.
- R3: `cmp_en` rises on the same edge as `perturb_req`, is never high while `perturb_req` is low, and in steady operation stays high for exactly WIN_TICKS `sw_tick` pulses.
- R4: During a search, `perturb_req` stays high for HIGH_TICKS ticks, and its rising edges repeat every PER_TICKS ticks.
- R5: After an iteration with no overshoot above the floor, the next code is c - d. Here d = (c>>3)+(c>>4)+(c>>7)+(c>>8), with d forced to at least 1, and the result is clamped to no lower than GAIN_MIN. The code always stays within [GAIN_MIN, GAIN_START].
- R6: `gain_code` never changes while `perturb_req` is high. A decision is taken only in the cycle just after `perturb_req` falls.
- R7: A comparator hit inside the window ends the search. `gain_code` returns to the code of the previous iteration (GAIN_START if the hit came on the first iteration), `done` goes to 1, and no further pulse or window is issued while `start` stays high.
- R8: An iteration at GAIN_MIN with no hit ends the search with `done`=1, `floor_hit`=1 and `gain_code`=GAIN_MIN.
- R9: `cmp_in` activity while `cmp_en` is low has no effect on the search. The comparator passes through a two-flop synchronizer and is gated by a window delayed to match.
- R10: Sampling `start` low outside idle aborts on that edge. `perturb_req` and `cmp_en` drop, `done` and `floor_hit` clear, and `gain_code` reloads GAIN_START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| start | input | 1 | Search permission from the calibration stage |
| cmp_in | input | 1 | Asynchronous overshoot comparator output |
| gain_code | output | GAIN_W | Code driven to the resistor bank |
| perturb_req | output | 1 | Step request to the control reference |
| cmp_en | output | 1 | Comparator enable window |
| done | output | 1 | Search finished |
| floor_hit | output | 1 | Search ended at GAIN_MIN without overshoot |

## Verification
The search is exercised with a hit on the first iteration, a hit on a middle iteration, a hit on a later iteration, and no hit at all. These separate the revert-to-previous rule, the staged decrement arithmetic and the floor exit. Runs with the comparator forced high whenever the window is shut show whether gating and synchronizer alignment keep stray activity out. An abort in the middle of a pulse tells a clean reload apart from a decision that leaks through. Steady-state iterations are timed in clock cycles to pin down the window length, pulse length and repeat period.

// File: rtl/dgt_pkg.sv
package dgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tune_state_e;

  // Roughly one fifth of the code: 1/8 + 1/16 + 1/128 + 1/256, at least one LSB.
  function automatic int gain_decrement(input int code);
    int d;
    d = (code >> 3) + (code >> 4) + (code >> 7) + (code >> 8);
    if (d < 1) d = 1;
    return d;
  endfunction

  // Next code after a quiet iteration, clamped at the floor.
  function automatic int gain_next(input int code, input int floor_code);
    int d;
    d = gain_decrement(code);
    if (code - d < floor_code) return floor_code;
    return code - d;
  endfunction

endpackage

// File: rtl/dgt_hit_catcher.sv
module dgt_hit_catcher #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  input  logic win_open,
  input  logic clear,
  output logic hit_seen
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] win_q;
  logic                   hit_pulse;
  logic                   sticky_q;

  // The window is delayed by the same depth as the synchronizer so that
  // each synchronized sample is judged against the window of its own cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      win_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_raw};
      win_q  <= {win_q[SYNC_STAGES-2:0], win_open};
    end
  end

  assign hit_pulse = sync_q[SYNC_STAGES-1] & win_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= 1'b0;
    else if (clear)     sticky_q <= 1'b0;
    else if (hit_pulse) sticky_q <= 1'b1;
  end

  assign hit_seen = sticky_q;

endmodule

// File: rtl/dgt_perturb_timer.sv
module dgt_perturb_timer #(
  parameter int PER_TICKS  = 16,
  parameter int HIGH_TICKS = 8,
  parameter int WIN_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_tick,
  input  logic go,
  input  logic halt,
  output logic perturb_req,
  output logic win_open,
  output logic iter_start,
  output logic fall_evt
);

  localparam int CW = $clog2(PER_TICKS + 1);
  localparam logic [CW-1:0] LAST_PER  = CW'(PER_TICKS - 1);
  localparam logic [CW-1:0] LAST_HIGH = CW'(HIGH_TICKS - 1);
  localparam logic [CW-1:0] LAST_WIN  = CW'(WIN_TICKS - 1);

  logic          active_q;
  logic          pulse_q;
  logic          win_q;
  logic          fall_q;
  logic [CW-1:0] cnt_q;
  logic          wrap_evt;

  assign wrap_evt   = active_q & ~pulse_q & sw_tick & (cnt_q == LAST_PER);
  assign iter_start = ~halt & ((go & ~active_q) | wrap_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pulse_q  <= 1'b0;
      win_q    <= 1'b0;
      fall_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      fall_q <= 1'b0;
      if (halt) begin
        active_q <= 1'b0;
        pulse_q  <= 1'b0;
        win_q    <= 1'b0;
        cnt_q    <= '0;
      end else if (iter_start) begin
        active_q <= 1'b1;
        pulse_q  <= 1'b1;
        win_q    <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q && sw_tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (win_q && cnt_q == LAST_WIN) win_q <= 1'b0;
        if (pulse_q && cnt_q == LAST_HIGH) begin
          pulse_q <= 1'b0;
          fall_q  <= 1'b1;
        end
      end
    end
  end

  assign perturb_req = pulse_q;
  assign win_open    = win_q;
  assign fall_evt    = fall_q;

endmodule

// File: rtl/dgt_gain_store.sv
module dgt_gain_store #(
  parameter int GAIN_W     = 8,
  parameter int GAIN_START = 200,
  parameter int GAIN_MIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              revert,
  output logic [GAIN_W-1:0] gain,
  output logic              at_min
);

  localparam logic [GAIN_W-1:0] START_C = GAIN_W'(GAIN_START);
  localparam logic [GAIN_W-1:0] MIN_C   = GAIN_W'(GAIN_MIN);

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] prev_q;
  logic [GAIN_W-1:0] next_c;

  assign next_c = GAIN_W'(dgt_pkg::gain_next(int'(gain_q), GAIN_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= START_C;
      prev_q <= START_C;
    end else if (load) begin
      gain_q <= START_C;
      prev_q <= START_C;
    end else if (revert) begin
      gain_q <= prev_q;
    end else if (step) begin
      prev_q <= gain_q;
      gain_q <= next_c;
    end
  end

  assign gain   = gain_q;
  assign at_min = (gain_q == MIN_C);

endmodule

// File: rtl/damp_gain_tuner.sv
module damp_gain_tuner #(
  parameter int GAIN_W      = 8,
  parameter int GAIN_START  = 200,
  parameter int GAIN_MIN    = 4,
  parameter int PER_TICKS   = 16,
  parameter int HIGH_TICKS  = 8,
  parameter int WIN_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_tick,
  input  logic              start,
  input  logic              cmp_in,
  output logic [GAIN_W-1:0] gain_code,
  output logic              perturb_req,
  output logic              cmp_en,
  output logic              done,
  output logic              floor_hit
);

  import dgt_pkg::*;

  tune_state_e state_q;
  logic        done_q;
  logic        floor_q;

  // Named internal events, also observed by the bound checker.
  logic go;
  logic abort;
  logic halt;
  logic iter_start;
  logic fall_evt;
  logic decide_evt;
  logic hit_seen;
  logic at_min;
  logic overshoot_end;
  logic floor_end;
  logic step_req;

  assign go            = (state_q == ST_IDLE) & start;
  assign abort         = (state_q != ST_IDLE) & ~start;
  assign decide_evt    = (state_q == ST_RUN) & fall_evt & start;
  assign overshoot_end = decide_evt & hit_seen;
  assign floor_end     = decide_evt & ~hit_seen & at_min;
  assign step_req      = decide_evt & ~hit_seen & ~at_min;
  assign halt          = abort | overshoot_end | floor_end;

  dgt_perturb_timer #(
    .PER_TICKS (PER_TICKS),
    .HIGH_TICKS(HIGH_TICKS),
    .WIN_TICKS (WIN_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_tick    (sw_tick),
    .go         (go),
    .halt       (halt),
    .perturb_req(perturb_req),
    .win_open   (cmp_en),
    .iter_start (iter_start),
    .fall_evt   (fall_evt)
  );

  dgt_hit_catcher #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_catch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_raw (cmp_in),
    .win_open(cmp_en),
    .clear   (iter_start),
    .hit_seen(hit_seen)
  );

  dgt_gain_store #(
    .GAIN_W    (GAIN_W),
    .GAIN_START(GAIN_START),
    .GAIN_MIN  (GAIN_MIN)
  ) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (abort),
    .step  (step_req),
    .revert(overshoot_end),
    .gain  (gain_code),
    .at_min(at_min)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      floor_q <= 1'b0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      floor_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) state_q <= ST_RUN;
        ST_RUN: begin
          if (overshoot_end) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else if (floor_end) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
            floor_q <= 1'b1;
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign done      = done_q;
  assign floor_hit = floor_q;

endmodule

// File: rtl/dgt_checker.sv
module dgt_checker #(
  parameter int GAIN_W     = 8,
  parameter int GAIN_START = 200,
  parameter int GAIN_MIN   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [GAIN_W-1:0] gain_code,
  input logic              perturb_req,
  input logic              cmp_en,
  input logic              done,
  input logic              floor_hit,
  input logic              decide_evt,
  input logic              hit_seen
);

  AST_WIN_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> perturb_req); // R3

  AST_WIN_OPENS_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_en) |-> $rose(perturb_req)); // R3

  AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gain_code) >= GAIN_MIN) && (int'(gain_code) <= GAIN_START)); // R5

  AST_STEP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code < $past(gain_code)) |->
      (int'(gain_code) == dgt_pkg::gain_next(int'($past(gain_code)), GAIN_MIN))); // R5

  AST_GAIN_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (perturb_req && $past(perturb_req)) |-> $stable(gain_code)); // R6

  AST_DECIDE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    decide_evt |-> (!perturb_req && $past(perturb_req))); // R6

  AST_HIT_ENDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_evt && hit_seen) |=> (done && !floor_hit)); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!perturb_req && !cmp_en)); // R7

  AST_FLOOR_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    floor_hit |-> (done && int'(gain_code) == GAIN_MIN)); // R8

  AST_STOP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!perturb_req && !done && !floor_hit)); // R10

endmodule

bind damp_gain_tuner dgt_checker #(
  .GAIN_W    (GAIN_W),
  .GAIN_START(GAIN_START),
  .GAIN_MIN  (GAIN_MIN)
) u_dgt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .gain_code  (gain_code),
  .perturb_req(perturb_req),
  .cmp_en     (cmp_en),
  .done       (done),
  .floor_hit  (floor_hit),
  .decide_evt (decide_evt),
  .hit_seen   (hit_seen)
);

// File: tb/damp_gain_tuner_test.sv
`timescale 1ns/1ps
module damp_gain_tuner_test;

  localparam int GW     = 8;
  localparam int G_START = 200;
  localparam int G_MIN  = 4;
  localparam int PER    = 16;
  localparam int HIGH   = 8;
  localparam int WIN    = 4;
  localparam int DIV    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tick = 1'b0;
  logic start = 1'b0;
  logic cmp_in = 1'b0;
  logic [GW-1:0] gain_code;
  logic perturb_req, cmp_en, done, floor_hit;

  always #10 clk = ~clk;

  damp_gain_tuner #(
    .GAIN_W(GW), .GAIN_START(G_START), .GAIN_MIN(G_MIN),
    .PER_TICKS(PER), .HIGH_TICKS(HIGH), .WIN_TICKS(WIN), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .start(start), .cmp_in(cmp_in),
    .gain_code(gain_code), .perturb_req(perturb_req), .cmp_en(cmp_en),
    .done(done), .floor_hit(floor_hit)
  );

  int n_tests = 0;
  int n_fail = 0;
  int exp_q[$];
  int cur_exp = 0;
  int it_cnt = 0;
  int os_iter = -1;
  bit spur = 1'b0;
  bit mon_on = 1'b0;
  int hi_cyc = 0, per_cyc = 0, win_cyc = 0;
  logic p_prev = 1'b0, w_prev = 1'b0;
  int cyc = 0;
  int div_cnt = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Reference decrement, written as integer division.
  function automatic int ref_next(input int c);
    int d;
    d = c / 8 + c / 16 + c / 128 + c / 256;
    if (d == 0) d = 1;
    if (c - d < G_MIN) return G_MIN;
    return c - d;
  endfunction

  // Monitor (scoreboard consumer), tick source and comparator model.
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (perturb_req && !p_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected iteration", int'(gain_code), -1);
        end else begin
          cur_exp = exp_q.pop_front();
          check(int'(gain_code) == cur_exp, "R5", "code at iteration start",
                int'(gain_code), cur_exp);
        end
        check(cmp_en == 1'b1, "R3", "window opens with pulse", int'(cmp_en), 1);
        if (it_cnt > 1)
          check(per_cyc == PER * DIV, "R4", "repeat period cycles", per_cyc, PER * DIV);
        it_cnt++;
        per_cyc = 0; hi_cyc = 0; win_cyc = 0;
      end
      if (!perturb_req && p_prev) begin
        check(int'(gain_code) == cur_exp, "R6", "code held through pulse",
              int'(gain_code), cur_exp);
        if (it_cnt > 1)
          check(hi_cyc == HIGH * DIV, "R4", "pulse high cycles", hi_cyc, HIGH * DIV);
      end
      if (!cmp_en && w_prev && it_cnt > 1)
        check(win_cyc == WIN * DIV, "R3", "window cycles", win_cyc, WIN * DIV);
    end
    if (perturb_req) hi_cyc++;
    if (cmp_en) win_cyc++;
    per_cyc++;
    p_prev = perturb_req;
    w_prev = cmp_en;
    if (!start) it_cnt = 0;
    div_cnt = (div_cnt + 1) % DIV;
    sw_tick = (div_cnt == 0);
    // Inside the window: fire only on the chosen iteration. Outside: stray level (R9).
    cmp_in = cmp_en ? (os_iter >= 0 && it_cnt - 1 == os_iter) : spur;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      check(1'b0, "WATCHDOG", "run did not end", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Driver: fills the scoreboard with the expected code sequence, runs one search.
  task automatic run_search(input int osi, input bit sp, input string tag);
    int g, prev, fin, flr;
    bit quiet;
    exp_q.delete();
    g = G_START; prev = G_START; fin = G_START; flr = 0;
    for (int i = 0; i < 300; i++) begin
      exp_q.push_back(g);
      if (i == osi) begin fin = prev; break; end
      if (g == G_MIN) begin fin = G_MIN; flr = 1; break; end
      prev = g;
      g = ref_next(g);
    end
    os_iter = osi; spur = sp; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check(perturb_req == 1'b1, "R2", "first pulse one edge after start", int'(perturb_req), 1);
    for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
    check(done == 1'b1, tag, "search finished", int'(done), 1);
    check(int'(gain_code) == fin, tag, "final code", int'(gain_code), fin);
    check(int'(floor_hit) == flr, "R8", "floor flag", int'(floor_hit), flr);
    check(exp_q.size() == 0, "R5", "all iterations seen", exp_q.size(), 0);
    quiet = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (perturb_req || cmp_en || int'(gain_code) != fin || !done) quiet = 1'b0;
    end
    check(quiet, "R7", "quiet and held after done", int'(quiet), 1);
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && floor_hit == 1'b0, "R10", "flags cleared on release",
          int'(done) + int'(floor_hit), 0);
    check(int'(gain_code) == G_START, "R10", "code reloaded on release",
          int'(gain_code), G_START);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    bit idle_ok;
    repeat (3) @(negedge clk);
    check(int'(gain_code) == G_START, "R1", "reset code", int'(gain_code), G_START);
    check(!perturb_req && !cmp_en && !done && !floor_hit, "R1", "reset outputs",
          int'(perturb_req) + int'(cmp_en) + int'(done) + int'(floor_hit), 0);
    rst_n = 1'b1;

    // Idle with the comparator stuck high: nothing must move.
    spur = 1'b1;
    idle_ok = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (perturb_req || cmp_en || done || int'(gain_code) != G_START) idle_ok = 1'b0;
    end
    check(idle_ok, "R2", "idle while start low", int'(idle_ok), 1);

    // Hit on the fourth iteration with stray comparator level outside windows.
    run_search(3, 1'b1, "R7");
    // Hit on the very first iteration.
    run_search(0, 1'b0, "R7");
    // No hit at all: walk down to the floor with stray activity (R9).
    run_search(-1, 1'b1, "R8");

    // Abort in the middle of the third pulse.
    exp_q.delete();
    exp_q.push_back(200); exp_q.push_back(162); exp_q.push_back(131);
    os_iter = -1; spur = 1'b0; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < 5000 && !(it_cnt == 3 && perturb_req); k++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(int'(gain_code) == 131, "R5", "code before abort", int'(gain_code), 131);
    mon_on = 1'b0;
    start = 1'b0;
    @(negedge clk);
    check(!perturb_req && !cmp_en, "R10", "pulse and window dropped",
          int'(perturb_req) + int'(cmp_en), 0);
    check(int'(gain_code) == G_START, "R10", "code reloaded on abort",
          int'(gain_code), G_START);
    exp_q.delete();
    repeat (10) @(negedge clk);

    // Later hit after the abort.
    run_search(5, 1'b0, "R7");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule